// File: doc/BRIEF.md
# PRBS Packet Self-Test Engine

This block is a built-in self-test engine for a byte-wide transmit and receive data path. Its generator runs a 15-bit linear feedback shift register and sends the resulting pseudo-random bytes as framed packets. The packet length and the idle gap between packets are both configurable. It can stop after a configured number of packets or run on until it is disabled. The generator produces its stream whether or not the checker is listening.

The checker is independent of the generator. It watches a byte-wide receive port and seeds its own predictor from the bytes it receives. It declares lock after a run of correct predictions. While locked, it counts received bytes and mismatching bytes. A run of mismatches makes it report loss of synchronisation and hunt again. In continuous mode the counters wrap. Otherwise they saturate. A synchronous clear input restarts the checker. In normal use the transmit port is looped back, directly or through a cable, to the receive port. The error-byte counter is then the measure of path integrity.

Top module: `prbs_bist`

## Requirements
- R1: The generator register is loaded with the seed at reset and is never cleared by anything else. It advances only on payload cycles, by 8 steps of the recurrence new_bit = s[14] ^ s[13], s = {s[13:0], new_bit}. Each payload byte is the low 8 bits of the advanced state, so the first new bit lands in bit 7.
- R2: Each packet is cfg_len consecutive cycles with tx_valid high. A length of 0 acts as 1. Consecutive packets of a run are separated by exactly cfg_gap cycles with tx_valid low, and a gap of 0 gives back-to-back packets.
- R3: A rising edge on gen_en starts a run in the next cycle. Outside continuous mode the run ends after cfg_pkts packets (0 acts as 1). Holding gen_en high after that does not restart it. Dropping gen_en ends a run in the next cycle. gen_busy is high exactly while a run is in progress, and tx_valid is high only while gen_busy is high.
- R4: With cfg_cont high, the generator keeps sending packets until gen_en drops.
- R5: While not locked, the checker predicts each byte as the 8-step continuation of the last 15 received bits. Bits not yet received count as zero. Lock is declared on the received byte that completes LOCK_N consecutive correct predictions.
- R6: Only while locked does every received byte increment byte_cnt, and each mismatching byte also increments err_cnt. In lock the predictor advances on its own and no longer follows the received data.
- R7: LOSS_N consecutive mismatching bytes while locked drop the lock and set chk_sync_lost, which stays high until a clear. Hunting then restarts with only the last received byte known.
- R8: With cfg_cont low, both counters saturate at 2^CNT_W-1. With cfg_cont high, a counter at its maximum goes to 0 on its next increment.
- R9: chk_clear synchronously returns the checker to hunting and zeroes both counters, the lock and chk_sync_lost. It overrides a byte received in the same cycle and does not disturb the generator.
- R10: After reset, tx_valid, gen_busy, chk_lock and chk_sync_lost are low and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_en | input | 1 | Generator enable; a rising edge starts a run, low stops it |
| cfg_cont | input | 1 | Continuous mode: endless run, wrapping counters |
| cfg_len | input | LEN_W | Payload bytes per packet |
| cfg_gap | input | GAP_W | Idle cycles between packets |
| cfg_pkts | input | PKT_W | Packets per run outside continuous mode |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit payload byte |
| gen_busy | output | 1 | Generator run in progress |
| chk_clear | input | 1 | Synchronous clear of checker state and counters |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive payload byte |
| chk_lock | output | 1 | Checker locked to the incoming stream |
| chk_sync_lost | output | 1 | Sticky flag: lock was lost since the last clear |
| err_cnt | output | CNT_W | Mismatching bytes received while locked |
| byte_cnt | output | CNT_W | Bytes received while locked |

## Verification
Two pairs of events can fall in the same cycle. In the first, the LOSS_N-th mismatching byte increments err_cnt and drops the lock on the same edge. In the second, chk_clear arrives together with a valid received byte. The bench provokes the first by XOR-corrupting a burst of eight looped-back bytes in the middle of a run. It provokes the second by raising the clear on a cycle where tx_valid is high. A bench model tracks lock, counts and the sticky flag byte by byte from the requirements, and every cycle is compared against it. This confirms that the error lands in the count on the cycle the lock drops, and that the cleared byte is not counted.

// File: rtl/prbs_bist_pkg.sv
// Shared definitions for the PRBS packet self-test engine.
// Assumes the 15-bit register with taps at bits 14 and 13 (x^15 + x^14 + 1).
package prbs_bist_pkg;

    localparam int LFSR_W = 15;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_DATA = 2'd1,
        GEN_GAP  = 2'd2
    } gen_state_e;

    // Advance the register by one byte: eight shifts, each appending s[14]^s[13].
    function automatic lfsr_t lfsr_adv8(input lfsr_t s);
        lfsr_t t;
        t = s;
        for (int i = 0; i < 8; i++) begin
            t = {t[LFSR_W-2:0], t[LFSR_W-1] ^ t[LFSR_W-2]};
        end
        return t;
    endfunction

endpackage

// File: rtl/prbs_cnt.sv
// Event counter for the checker statistics.
// Increments once per cycle when inc is high. At all-ones it either wraps to
// zero (wrap high) or holds. A synchronous clear has priority over inc.
module prbs_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic         wrap,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};

    // Count, wrap or saturate, clear first.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (inc) begin
            if (q == MAXV) begin
                q <= wrap ? '0 : MAXV;
            end else begin
                q <= q + W'(1);
            end
        end
    end

endmodule

// File: rtl/prbs_gen.sv
// Packet generator: frames PRBS payload bytes into packets with idle gaps.
// Assumes configuration is held stable while a run is in progress. The
// register only advances on payload cycles, so the stream is seamless
// across gaps and across runs.
module prbs_gen
    import prbs_bist_pkg::*;
#(
    parameter int    LEN_W = 12,
    parameter int    GAP_W = 8,
    parameter int    PKT_W = 16,
    parameter lfsr_t SEED  = 15'h1ACE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cont,
    input  logic [LEN_W-1:0] len,
    input  logic [GAP_W-1:0] gap,
    input  logic [PKT_W-1:0] pkts,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             busy
);

    gen_state_e       state;
    lfsr_t            lfsr;
    lfsr_t            lfsr_nx;
    logic             en_q;
    logic [LEN_W-1:0] idx;
    logic [GAP_W-1:0] gcnt;
    logic [PKT_W-1:0] pcnt;
    logic [LEN_W-1:0] len_eff;
    logic [PKT_W-1:0] pkts_eff;

    // Zero length or packet count behaves as one.
    always_comb begin
        len_eff  = (len  == '0) ? LEN_W'(1) : len;
        pkts_eff = (pkts == '0) ? PKT_W'(1) : pkts;
        lfsr_nx  = lfsr_adv8(lfsr);
    end

    assign tx_valid = (state == GEN_DATA);
    assign tx_data  = lfsr_nx[7:0];
    assign busy     = (state != GEN_IDLE);

    // Run sequencer: start on enable edge, count bytes, gaps and packets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= GEN_IDLE;
            lfsr  <= SEED;
            en_q  <= 1'b0;
            idx   <= '0;
            gcnt  <= '0;
            pcnt  <= '0;
        end else begin
            en_q <= en;
            case (state)
                GEN_IDLE: begin
                    if (en && !en_q) begin
                        state <= GEN_DATA;
                        idx   <= '0;
                        pcnt  <= '0;
                    end
                end
                GEN_DATA: begin
                    lfsr <= lfsr_nx;
                    if (idx == len_eff - LEN_W'(1)) begin
                        idx <= '0;
                        if (!cont && pcnt == pkts_eff - PKT_W'(1)) begin
                            state <= GEN_IDLE;
                        end else begin
                            pcnt <= pcnt + PKT_W'(1);
                            gcnt <= '0;
                            state <= (gap == '0) ? GEN_DATA : GEN_GAP;
                        end
                    end else begin
                        idx <= idx + LEN_W'(1);
                    end
                end
                GEN_GAP: begin
                    if (gcnt == gap - GAP_W'(1)) begin
                        state <= GEN_DATA;
                    end else begin
                        gcnt <= gcnt + GAP_W'(1);
                    end
                end
                default: state <= GEN_IDLE;
            endcase
            if (!en) begin
                state <= GEN_IDLE;
            end
        end
    end

endmodule

// File: rtl/prbs_chk.sv
// Self-synchronising PRBS checker with lock, sync-loss and statistics.
// While hunting it shifts received bytes into its predictor. While locked the
// predictor runs free. Counting happens only while locked.
module prbs_chk
    import prbs_bist_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int LOCK_N = 4,
    parameter int LOSS_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cont,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             lock,
    output logic             sync_lost,
    output logic [CNT_W-1:0] err_cnt,
    output logic [CNT_W-1:0] byte_cnt
);

    localparam int GOOD_W = $clog2(LOCK_N + 1);
    localparam int BAD_W  = $clog2(LOSS_N + 1);

    lfsr_t             st;
    lfsr_t             pred;
    logic              match;
    logic [GOOD_W-1:0] good;
    logic [BAD_W-1:0]  bad;
    logic              cnt_byte;
    logic              cnt_err;

    // Prediction of the current byte and its comparison.
    always_comb begin
        pred     = lfsr_adv8(st);
        match    = (rx_data == pred[7:0]);
        cnt_byte = rx_valid && lock;
        cnt_err  = cnt_byte && !match;
    end

    // Hunt/lock state machine with sticky loss flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st        <= '0;
            lock      <= 1'b0;
            sync_lost <= 1'b0;
            good      <= '0;
            bad       <= '0;
        end else if (rx_valid) begin
            if (!lock) begin
                st <= {st[LFSR_W-9:0], rx_data};
                if (match) begin
                    if (good == GOOD_W'(LOCK_N - 1)) begin
                        lock <= 1'b1;
                        good <= '0;
                        bad  <= '0;
                    end else begin
                        good <= good + GOOD_W'(1);
                    end
                end else begin
                    good <= '0;
                end
            end else if (match) begin
                st  <= pred;
                bad <= '0;
            end else if (bad == BAD_W'(LOSS_N - 1)) begin
                st        <= {{(LFSR_W-8){1'b0}}, rx_data};
                lock      <= 1'b0;
                sync_lost <= 1'b1;
                bad       <= '0;
                good      <= '0;
            end else begin
                st  <= pred;
                bad <= bad + BAD_W'(1);
            end
        end
    end

    prbs_cnt #(.W(CNT_W)) u_err_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .inc  (cnt_err),
        .wrap (cont),
        .q    (err_cnt)
    );

    prbs_cnt #(.W(CNT_W)) u_byte_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .inc  (cnt_byte),
        .wrap (cont),
        .q    (byte_cnt)
    );

endmodule

// File: rtl/prbs_bist.sv
// Top of the PRBS packet self-test engine: an independent generator and
// checker sharing only the continuous-mode setting.
// Assumes rx_* is fed from a loopback of tx_* in normal use.
module prbs_bist
    import prbs_bist_pkg::*;
#(
    parameter int    LEN_W  = 12,
    parameter int    GAP_W  = 8,
    parameter int    PKT_W  = 16,
    parameter int    CNT_W  = 16,
    parameter int    LOCK_N = 4,
    parameter int    LOSS_N = 8,
    parameter lfsr_t SEED   = 15'h1ACE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             cfg_cont,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [GAP_W-1:0] cfg_gap,
    input  logic [PKT_W-1:0] cfg_pkts,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             gen_busy,
    input  logic             chk_clear,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             chk_lock,
    output logic             chk_sync_lost,
    output logic [CNT_W-1:0] err_cnt,
    output logic [CNT_W-1:0] byte_cnt
);

    prbs_gen #(
        .LEN_W(LEN_W),
        .GAP_W(GAP_W),
        .PKT_W(PKT_W),
        .SEED (SEED)
    ) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (gen_en),
        .cont    (cfg_cont),
        .len     (cfg_len),
        .gap     (cfg_gap),
        .pkts    (cfg_pkts),
        .tx_valid(tx_valid),
        .tx_data (tx_data),
        .busy    (gen_busy)
    );

    prbs_chk #(
        .CNT_W (CNT_W),
        .LOCK_N(LOCK_N),
        .LOSS_N(LOSS_N)
    ) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (chk_clear),
        .cont     (cfg_cont),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .lock     (chk_lock),
        .sync_lost(chk_sync_lost),
        .err_cnt  (err_cnt),
        .byte_cnt (byte_cnt)
    );

endmodule

// File: rtl/prbs_bist_sva.sv
// Port-level temporal checks for prbs_bist, attached by bind.
module prbs_bist_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gen_en,
    input logic             cfg_cont,
    input logic             tx_valid,
    input logic             gen_busy,
    input logic             chk_clear,
    input logic             rx_valid,
    input logic             chk_lock,
    input logic             chk_sync_lost,
    input logic [CNT_W-1:0] err_cnt,
    input logic [CNT_W-1:0] byte_cnt
);

    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    assert_valid_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> gen_busy);

    assert_disable_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> !gen_busy);

    assert_hunt_no_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !chk_lock && !chk_clear) |=> ($stable(err_cnt) && $stable(byte_cnt)));

    assert_idle_no_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !chk_clear) |=> ($stable(err_cnt) && $stable(byte_cnt)));

    assert_loss_from_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chk_sync_lost) |-> $past(chk_lock));

    assert_lock_drop_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chk_lock) |-> (chk_sync_lost || $past(chk_clear)));

    assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_cont && !chk_clear && byte_cnt == MAXV) |=> (byte_cnt == MAXV));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chk_clear |=> (!chk_lock && !chk_sync_lost && err_cnt == '0 && byte_cnt == '0));

endmodule

bind prbs_bist prbs_bist_sva #(.CNT_W(CNT_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .gen_en       (gen_en),
    .cfg_cont     (cfg_cont),
    .tx_valid     (tx_valid),
    .gen_busy     (gen_busy),
    .chk_clear    (chk_clear),
    .rx_valid     (rx_valid),
    .chk_lock     (chk_lock),
    .chk_sync_lost(chk_sync_lost),
    .err_cnt      (err_cnt),
    .byte_cnt     (byte_cnt)
);

// File: tb/sim_prbs_bist.sv
`timescale 1ns/1ps
module sim_prbs_bist;

    localparam int          LEN_W  = 12;
    localparam int          GAP_W  = 8;
    localparam int          PKT_W  = 16;
    localparam int          CNT_W  = 8;
    localparam int          LOCK_N = 4;
    localparam int          LOSS_N = 8;
    localparam logic [14:0] SEED   = 15'h1ACE;
    localparam longint      CMAX   = (64'd1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             gen_en = 1'b0;
    logic             cfg_cont = 1'b0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic [GAP_W-1:0] cfg_gap = '0;
    logic [PKT_W-1:0] cfg_pkts = '0;
    logic             chk_clear = 1'b0;
    logic [7:0]       inj = 8'h00;
    logic             tx_valid, gen_busy, chk_lock, chk_sync_lost;
    logic [7:0]       tx_data;
    logic [7:0]       rx_d;
    logic [CNT_W-1:0] err_cnt, byte_cnt;

    int n_chk = 0;
    int n_bad = 0;

    assign rx_d = tx_data ^ inj;

    always #4 clk = ~clk;

    prbs_bist #(
        .LEN_W(LEN_W), .GAP_W(GAP_W), .PKT_W(PKT_W), .CNT_W(CNT_W),
        .LOCK_N(LOCK_N), .LOSS_N(LOSS_N), .SEED(SEED)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .cfg_cont(cfg_cont),
        .cfg_len(cfg_len), .cfg_gap(cfg_gap), .cfg_pkts(cfg_pkts),
        .tx_valid(tx_valid), .tx_data(tx_data), .gen_busy(gen_busy),
        .chk_clear(chk_clear), .rx_valid(tx_valid), .rx_data(rx_d),
        .chk_lock(chk_lock), .chk_sync_lost(chk_sync_lost),
        .err_cnt(err_cnt), .byte_cnt(byte_cnt)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Spec recurrence for one byte: eight steps of s[14]^s[13] appended at the bottom.
    function automatic logic [14:0] step8(input logic [14:0] s);
        logic [14:0] t = s;
        for (int i = 0; i < 8; i++) t = {t[13:0], t[14] ^ t[13]};
        return t;
    endfunction

    function automatic longint bump(input longint v);
        if (v == CMAX) return cfg_cont ? 0 : CMAX;
        return v + 1;
    endfunction

    // Checker reference state
    logic [14:0] m_st;
    int          m_good, m_bad;
    bit          m_lock, m_lost;
    longint      m_err, m_byte;

    task automatic m_clear();
        m_st = '0; m_good = 0; m_bad = 0; m_lock = 0; m_lost = 0; m_err = 0; m_byte = 0;
    endtask

    task automatic m_rx(input logic [7:0] b);
        logic [14:0] p;
        p = step8(m_st);
        if (!m_lock) begin
            m_st   = {m_st[6:0], b};
            m_good = (b == p[7:0]) ? m_good + 1 : 0;
            if (m_good == LOCK_N) begin m_lock = 1; m_good = 0; m_bad = 0; end
        end else begin
            m_byte = bump(m_byte);
            if (b == p[7:0]) begin
                m_st = p; m_bad = 0;
            end else begin
                m_err = bump(m_err);
                m_bad++;
                if (m_bad == LOSS_N) begin
                    m_lock = 0; m_lost = 1; m_bad = 0; m_good = 0; m_st = {7'b0, b};
                end else m_st = p;
            end
        end
    endtask

    // Generator reference state
    logic [14:0] g_st;
    bit          in_pkt, had_pkt, aborting;
    int          cur_len, gap_cnt, pkts_seen;

    function automatic int len_eff();
        return (cfg_len == 0) ? 1 : int'(cfg_len);
    endfunction

    // Per-cycle monitor: compare against references, then consume this cycle's byte.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_clear();
            g_st = SEED; in_pkt = 0; had_pkt = 0; cur_len = 0; gap_cnt = 0;
        end else begin
            check(chk_lock == m_lock, "R5 lock", chk_lock, m_lock);
            check(chk_sync_lost == m_lost, "R7 sync_lost", chk_sync_lost, m_lost);
            check(err_cnt == m_err, "R6/R8 err_cnt", err_cnt, m_err);
            check(byte_cnt == m_byte, "R6/R8 byte_cnt", byte_cnt, m_byte);
            if (tx_valid) begin
                logic [14:0] e;
                e = step8(g_st);
                check(tx_data == e[7:0], "R1 tx_data", tx_data, e[7:0]);
                g_st = e;
                if (in_pkt && cur_len == len_eff()) begin
                    check(cfg_gap == 0, "R2 gap", 0, cfg_gap);
                    pkts_seen++; cur_len = 0;
                end else if (!in_pkt) begin
                    if (had_pkt) check(gap_cnt == cfg_gap, "R2 gap", gap_cnt, cfg_gap);
                    in_pkt = 1; cur_len = 0;
                end
                cur_len++;
            end else begin
                if (in_pkt) begin
                    if (!aborting) check(cur_len == len_eff(), "R2 length", cur_len, len_eff());
                    pkts_seen++; in_pkt = 0; had_pkt = 1; gap_cnt = 0;
                end
                if (gen_busy) gap_cnt++;
                else had_pkt = 0;
            end
            if (chk_clear) m_clear();
            else if (tx_valid) m_rx(rx_d);
        end
    end

    int burst_left = 0;
    int err_pct = 0;

    // One clock: inputs change one ns after the rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
        chk_clear = 1'b0;
        if (burst_left > 0) begin
            inj = 8'h5A;
            if (tx_valid) burst_left--;
        end else if (err_pct > 0 && $urandom_range(99) < err_pct) begin
            inj = 8'($urandom_range(255, 1));
        end else begin
            inj = 8'h00;
        end
    endtask

    task automatic run_pkts(input int len, input int gap, input int pkts);
        cfg_cont = 0; cfg_len = LEN_W'(len); cfg_gap = GAP_W'(gap); cfg_pkts = PKT_W'(pkts);
        pkts_seen = 0; aborting = 0;
        gen_en = 1;
        tick(); tick();
        for (int i = 0; i < 20000 && gen_busy; i++) tick();
        tick(); tick();
        check(pkts_seen == ((pkts == 0) ? 1 : pkts), "R3 packet count", pkts_seen, pkts);
        check(gen_busy == 0, "R3 run ended", gen_busy, 0);
        gen_en = 0;
        tick();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) tick();
        rst_n = 1;
        @(negedge clk);
        check(!tx_valid && !gen_busy, "R10 generator idle", {tx_valid, gen_busy}, 0);
        check(!chk_lock && !chk_sync_lost, "R10 checker flags", {chk_lock, chk_sync_lost}, 0);
        check(err_cnt == 0 && byte_cnt == 0, "R10 counters", byte_cnt, 0);

        // Clean loopback, directed framing
        run_pkts(5, 3, 6);
        check(chk_lock == 1, "R5 locked after clean run", chk_lock, 1);
        check(err_cnt == 0, "R6 no errors on clean path", err_cnt, 0);
        check(byte_cnt == 30 - 6, "R5 lock after 6 bytes from cold start", byte_cnt, 24);

        // Zero length and zero gap
        run_pkts(0, 0, 3);

        // Held enable does not re-arm
        gen_en = 1;
        cfg_len = 4; cfg_gap = 1; cfg_pkts = 2; pkts_seen = 0;
        tick(); tick();
        for (int i = 0; i < 100 && gen_busy; i++) tick();
        repeat (10) tick();
        check(gen_busy == 0, "R3 no restart while enable held", gen_busy, 0);
        gen_en = 0; tick();

        // Error burst mid-run: last error and lock drop coincide
        cfg_len = 20; cfg_gap = 2; cfg_pkts = 8; pkts_seen = 0; aborting = 0;
        gen_en = 1;
        repeat (40) tick();
        burst_left = LOSS_N;
        for (int i = 0; i < 2000 && gen_busy; i++) tick();
        tick(); tick();
        check(chk_sync_lost == 1, "R7 loss flagged after burst", chk_sync_lost, 1);
        check(chk_lock == 1, "R7 relocked after burst", chk_lock, 1);
        check(err_cnt >= LOSS_N, "R6 burst errors counted", err_cnt, LOSS_N);
        gen_en = 0; tick();

        // Clear together with a valid byte, generator keeps running
        cfg_len = 10; cfg_gap = 2; cfg_pkts = 5; pkts_seen = 0;
        gen_en = 1;
        repeat (8) tick();
        while (!tx_valid) tick();
        chk_clear = 1;
        @(negedge clk);
        @(posedge clk); #1; chk_clear = 0;
        @(negedge clk);
        check(byte_cnt == 0 && err_cnt == 0, "R9 clear wins over byte", byte_cnt, 0);
        check(!chk_lock && !chk_sync_lost, "R9 flags cleared", {chk_lock, chk_sync_lost}, 0);
        check(gen_busy == 1, "R9 generator unaffected", gen_busy, 1);
        for (int i = 0; i < 2000 && gen_busy; i++) tick();
        tick(); tick();
        check(pkts_seen == 5, "R9 generator completes run", pkts_seen, 5);
        gen_en = 0; tick();

        // Random runs with sparse corruption
        for (int r = 0; r < 6; r++) begin
            err_pct = $urandom_range(3);
            run_pkts($urandom_range(24, 1), $urandom_range(6), $urandom_range(6, 1));
        end
        err_pct = 0;

        // Saturation outside continuous mode
        chk_clear = 1; tick();
        run_pkts(40, 1, 10);
        check(byte_cnt == CMAX, "R8 byte count saturates", byte_cnt, CMAX);

        // Continuous mode: endless run, wrapping counters
        chk_clear = 1; tick();
        cfg_cont = 1; cfg_len = 30; cfg_gap = 2; cfg_pkts = 1; pkts_seen = 0; aborting = 0;
        gen_en = 1;
        repeat (600) tick();
        check(gen_busy == 1, "R4 still running", gen_busy, 1);
        check(pkts_seen > 1, "R4 more packets than configured", pkts_seen, 2);
        check(byte_cnt < 100, "R8 byte count wrapped", byte_cnt, 100);
        aborting = 1;
        gen_en = 0;
        tick();
        check(gen_busy == 0, "R4 stops on disable", gen_busy, 0);
        tick(); tick();
        aborting = 0; cfg_cont = 0;

        // Abort a bounded run
        cfg_len = 50; cfg_gap = 0; cfg_pkts = 4; aborting = 1;
        gen_en = 1;
        repeat (30) tick();
        gen_en = 0;
        tick();
        check(gen_busy == 0 && tx_valid == 0, "R3 abort ends run", gen_busy, 0);
        tick(); tick();
        aborting = 0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1600000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule